// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with Packing

This block buffers outgoing audio samples between a processor write port and a codec link. The processor writes 32-bit words. The block turns each word into one or two samples, each 20 bits wide and left-justified, and places them in a small circular store. A control word sets the channel enable, the sample size, compact packing and two slot enables. Compact packing puts two short samples in one word.

Samples leave through a stereo pair port that uses a valid/ready handshake. A burst starts only when the store is at least half full. The burst then moves one left/right pair per cycle for as long as the codec accepts each pair. Registered status flags report empty, half-empty, full and underrun. A three-bit interrupt status is derived from these flags and gated by a mask into one interrupt line. Driving the link-enable input low flushes the block in the same way as reset.

Top module: `audio_tx_fifo`

## Requirements
- R1: The size code selects the sample width: 0 is 16-bit, 1 is 18-bit, 2 is 20-bit and 3 is 12-bit. In non-compact mode a written word is shifted left by 4, 2, 0 or 8 bits for those codes. The result is cut to its low 20 bits and stored as one entry.
- R2: In compact mode a word becomes two entries, the low halfword first and the high halfword second. Each halfword is shifted left by 8 for code 3 and by 4 otherwise, then cut to 20 bits. A compact request made together with code 1 or 2 is stored as non-compact.
- R3: A non-compact write is accepted only while level < DEPTH. A compact write is accepted only while level + 2 < DEPTH. A refused write leaves the level and the stored data unchanged.
- R4: After any data write, empty and underrun clear when the level is above 0, and half-empty clears when the level is at least DEPTH/2. Full is set exactly when the level equals DEPTH.
- R5: pair_valid is high only when all of the following hold: the channel is enabled, at least one slot enable is set, and the level is at least 2. In addition, either the level is at least DEPTH/2, or a pair was taken on the previous cycle. pair_left carries the older of the two entries.
- R6: When a pair is taken, full clears. Half-empty sets if the resulting level is at most DEPTH/2. Empty and underrun both set if the resulting level is 0.
- R7: int_status bit 0 is underrun, bit 1 is half-empty, and bit 2 is transfer-complete, which is empty while pair_valid is low. irq is high when any int_status bit is set together with the same bit of the mask.
- R8: clr_we together with clr_underrun clears underrun. If a pair drains the store to 0 in the same cycle, underrun is set instead.
- R9: Reset, or a cycle with link_en low, empties the store and clears the control word and the mask. It also leaves the flags with empty=1, half-empty=1, full=0 and underrun=0. A data write in that cycle is discarded.
- R10: A pair is removed only on a cycle where pair_valid and pair_ready are both high. If an accepted write happens in the same cycle, the level changes by the net amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Interface enable; low flushes the block |
| ctl_we | input | 1 | Load the control word |
| ctl_chan_en | input | 1 | Channel enable |
| ctl_size | input | 2 | Sample size code |
| ctl_compact | input | 1 | Compact packing request |
| ctl_slot_en | input | 2 | Slot enables; either one permits transfers |
| dat_we | input | 1 | Data write strobe |
| dat_word | input | 32 | Data word |
| clr_we | input | 1 | Clear-register write strobe |
| clr_underrun | input | 1 | Underrun-clear bit |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 3 | Interrupt mask value |
| pair_valid | output | 1 | A stereo pair is offered |
| pair_ready | input | 1 | The codec takes the pair |
| pair_left | output | 20 | Left sample (older entry) |
| pair_right | output | 20 | Right sample (newer entry) |
| fifo_level | output | $clog2(DEPTH+1) | Number of stored entries |
| st_empty | output | 1 | Empty flag |
| st_half_empty | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_underrun | output | 1 | Underrun flag |
| int_status | output | 3 | Raw interrupt status |
| irq | output | 1 | Masked interrupt line |

## Verification
A data write and a pair removal can land in the same cycle. The bench provokes this by writing a word just as a burst opens with pair_ready held high. It then requires the level to move by the net amount and the next pair to come from the right entries. A second collision sets an underrun clear against the final pop that empties the store, and underrun must stay set. A third drives a data write during a link_en-low cycle, and that write must leave no trace.

// File: rtl/atx_pkg.sv
`timescale 1ns/1ps
package atx_pkg;
   localparam int SMP_W  = 20;
   localparam int WORD_W = 32;
   localparam int HALF_W = 16;
   localparam int INT_W  = 3;

   typedef enum logic [1:0] {
      SZ_16 = 2'd0,
      SZ_18 = 2'd1,
      SZ_20 = 2'd2,
      SZ_12 = 2'd3
   } smp_size_e;

   typedef struct packed {
      logic       chan_en;
      smp_size_e  size;
      logic       compact;
      logic [1:0] slot_en;
   } tx_ctl_t;

   // left shift that left-justifies a non-compact sample in 20 bits
   function automatic logic [4:0] nc_shift(smp_size_e s);
      case (s)
         SZ_12:   return 5'd8;
         SZ_16:   return 5'd4;
         SZ_18:   return 5'd2;
         default: return 5'd0;
      endcase
   endfunction

   function automatic logic compact_allowed(smp_size_e s);
      return (s == SZ_16) || (s == SZ_12);
   endfunction
endpackage

// File: rtl/atx_packer.sv
`timescale 1ns/1ps
module atx_packer
   import atx_pkg::*;
(
   input  logic [WORD_W-1:0]           word,
   input  smp_size_e                   size,
   input  logic                        compact,
   output logic [1:0][SMP_W-1:0]       smp
);
   localparam int EXT_W = HALF_W + 8;

   logic [WORD_W-1:0] nc_word;
   assign nc_word = word << nc_shift(size);

   genvar g;
   generate
      for (g = 0; g < 2; g++) begin : g_lane
         logic [EXT_W-1:0] ext;
         logic [SMP_W-1:0] cmp_smp;
         assign ext     = {8'd0, word[g*HALF_W +: HALF_W]} << ((size == SZ_12) ? 8 : 4);
         assign cmp_smp = ext[SMP_W-1:0];
         if (g == 0) begin : g_first
            assign smp[g] = compact ? cmp_smp : nc_word[SMP_W-1:0];
         end else begin : g_second
            assign smp[g] = cmp_smp;
         end
      end
   endgenerate
endmodule

// File: rtl/atx_store.sv
`timescale 1ns/1ps
module atx_store
   import atx_pkg::*;
#(
   parameter  int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic [1:0]            push_cnt,
   input  logic [1:0][SMP_W-1:0] push_smp,
   input  logic                  pop,
   output logic [LVL_W-1:0]      level,
   output logic [LVL_W-1:0]      lvl_pushed,
   output logic [LVL_W-1:0]      lvl_next,
   output logic [1:0][SMP_W-1:0] head
);
   logic [SMP_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr1, rd_ptr1;
   logic [LVL_W-1:0] level_q;

   assign wr_ptr1    = wr_ptr + PTR_W'(1);
   assign rd_ptr1    = rd_ptr + PTR_W'(1);
   assign lvl_pushed = level_q + LVL_W'(push_cnt);
   assign lvl_next   = lvl_pushed - (pop ? LVL_W'(2) : LVL_W'(0));
   assign level      = level_q;
   assign head[0]    = mem[rd_ptr];
   assign head[1]    = mem[rd_ptr1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
      end else if (flush) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
      end else begin
         if (push_cnt != 2'd0) wr_ptr <= wr_ptr + PTR_W'(push_cnt);
         if (pop)              rd_ptr <= rd_ptr + PTR_W'(2);
         level_q <= lvl_next;
      end
   end

   always_ff @(posedge clk) begin
      if (!flush && push_cnt != 2'd0) mem[wr_ptr]  <= push_smp[0];
      if (!flush && push_cnt == 2'd2) mem[wr_ptr1] <= push_smp[1];
   end
endmodule

// File: rtl/atx_flags.sv
`timescale 1ns/1ps
module atx_flags #(
   parameter  int DEPTH = 8,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_evt,
   input  logic [LVL_W-1:0] lvl_pushed,
   input  logic             pop,
   input  logic [LVL_W-1:0] lvl_next,
   input  logic             clr_ur,
   output logic             empty,
   output logic             half_empty,
   output logic             full,
   output logic             underrun
);
   localparam logic [LVL_W-1:0] HALF_L = LVL_W'(DEPTH / 2);
   localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);

   logic e_n, h_n, f_n, u_n;

   // write effects first, drain effects second, so drain wins on a tie
   always_comb begin
      e_n = empty;
      h_n = half_empty;
      f_n = full;
      u_n = underrun;
      if (clr_ur) u_n = 1'b0;
      if (wr_evt) begin
         if (lvl_pushed != '0) begin
            e_n = 1'b0;
            u_n = 1'b0;
         end
         if (lvl_pushed >= HALF_L) h_n = 1'b0;
         if (lvl_pushed >= FULL_L) f_n = 1'b1;
      end
      if (pop) begin
         f_n = 1'b0;
         if (lvl_next <= HALF_L) h_n = 1'b1;
         if (lvl_next == '0) begin
            e_n = 1'b1;
            u_n = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty <= 1'b1; half_empty <= 1'b1; full <= 1'b0; underrun <= 1'b0;
      end else if (flush) begin
         empty <= 1'b1; half_empty <= 1'b1; full <= 1'b0; underrun <= 1'b0;
      end else begin
         empty <= e_n; half_empty <= h_n; full <= f_n; underrun <= u_n;
      end
   end
endmodule

// File: rtl/audio_tx_fifo.sv
`timescale 1ns/1ps
module audio_tx_fifo
   import atx_pkg::*;
#(
   parameter  int DEPTH = 8,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    link_en,
   input  logic                    ctl_we,
   input  logic                    ctl_chan_en,
   input  logic [1:0]              ctl_size,
   input  logic                    ctl_compact,
   input  logic [1:0]              ctl_slot_en,
   input  logic                    dat_we,
   input  logic [WORD_W-1:0]       dat_word,
   input  logic                    clr_we,
   input  logic                    clr_underrun,
   input  logic                    mask_we,
   input  logic [INT_W-1:0]        mask_data,
   output logic                    pair_valid,
   input  logic                    pair_ready,
   output logic [SMP_W-1:0]        pair_left,
   output logic [SMP_W-1:0]        pair_right,
   output logic [LVL_W-1:0]        fifo_level,
   output logic                    st_empty,
   output logic                    st_half_empty,
   output logic                    st_full,
   output logic                    st_underrun,
   output logic [INT_W-1:0]        int_status,
   output logic                    irq
);
   localparam logic [LVL_W-1:0] HALF_L = LVL_W'(DEPTH / 2);
   localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("audio_tx_fifo: DEPTH must be a power of two of at least 4");
      end
   endgenerate

   tx_ctl_t               ctl_q;
   logic [INT_W-1:0]      mask_q;
   logic                  draining_q;
   logic                  flush, pop, room;
   logic [1:0]            push_cnt;
   logic [1:0][SMP_W-1:0] packed_smp, head;
   logic [LVL_W-1:0]      lvl_pushed, lvl_next, lvl_plus2;

   assign flush = !link_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         mask_q     <= '0;
         draining_q <= 1'b0;
      end else if (flush) begin
         ctl_q      <= '0;
         mask_q     <= '0;
         draining_q <= 1'b0;
      end else begin
         if (ctl_we) begin
            ctl_q.chan_en <= ctl_chan_en;
            ctl_q.size    <= smp_size_e'(ctl_size);
            ctl_q.compact <= ctl_compact && compact_allowed(smp_size_e'(ctl_size));
            ctl_q.slot_en <= ctl_slot_en;
         end
         if (mask_we) mask_q <= mask_data;
         draining_q <= pop;
      end
   end

   atx_packer u_pack (
      .word    (dat_word),
      .size    (ctl_q.size),
      .compact (ctl_q.compact),
      .smp     (packed_smp)
   );

   assign lvl_plus2 = fifo_level + LVL_W'(2);
   assign room      = ctl_q.compact ? (lvl_plus2 < FULL_L) : (fifo_level < FULL_L);
   assign push_cnt  = (link_en && dat_we && room) ? (ctl_q.compact ? 2'd2 : 2'd1) : 2'd0;

   assign pair_valid = ctl_q.chan_en && (ctl_q.slot_en != 2'b00) &&
                       (fifo_level >= LVL_W'(2)) &&
                       ((fifo_level >= HALF_L) || draining_q);
   assign pop        = pair_valid && pair_ready;

   atx_store #(.DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .push_cnt   (push_cnt),
      .push_smp   (packed_smp),
      .pop        (pop),
      .level      (fifo_level),
      .lvl_pushed (lvl_pushed),
      .lvl_next   (lvl_next),
      .head       (head)
   );

   assign pair_left  = head[0];
   assign pair_right = head[1];

   atx_flags #(.DEPTH(DEPTH)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .wr_evt     (dat_we),
      .lvl_pushed (lvl_pushed),
      .pop        (pop),
      .lvl_next   (lvl_next),
      .clr_ur     (clr_we && clr_underrun),
      .empty      (st_empty),
      .half_empty (st_half_empty),
      .full       (st_full),
      .underrun   (st_underrun)
   );

   assign int_status = {st_empty && !pair_valid, st_half_empty, st_underrun};
   assign irq        = |(int_status & mask_q);
endmodule

// File: rtl/atx_fifo_chk.sv
`timescale 1ns/1ps
module atx_fifo_chk #(
   parameter  int DEPTH = 8,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             link_en,
   input logic             dat_we,
   input logic             pair_valid,
   input logic             pair_ready,
   input logic [LVL_W-1:0] fifo_level,
   input logic             st_empty,
   input logic             st_half_empty,
   input logic             st_full,
   input logic             st_underrun
);
   localparam logic [LVL_W-1:0] HALF_L = LVL_W'(DEPTH / 2);
   localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);

   a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= FULL_L);
   a_r4_full_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      st_full == (fifo_level == FULL_L));
   a_r6_empty_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      st_empty == (fifo_level == '0));
   a_r6_underrun_implies_empty: assert property (@(posedge clk) disable iff (!rst_n)
      st_underrun |-> st_empty);
   a_r5_pair_has_two: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> fifo_level >= LVL_W'(2));
   a_r5_burst_starts_half: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pair_valid) |-> fifo_level >= HALF_L);
   a_r10_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (link_en && !dat_we && !(pair_valid && pair_ready)) |=> fifo_level == $past(fifo_level));
   a_r10_pop_takes_two: assert property (@(posedge clk) disable iff (!rst_n)
      (link_en && !dat_we && pair_valid && pair_ready) |=>
         fifo_level == ($past(fifo_level) - LVL_W'(2)));
   a_r9_flush_state: assert property (@(posedge clk) disable iff (!rst_n)
      !link_en |=> (fifo_level == '0 && st_empty && st_half_empty && !st_underrun && !st_full));
endmodule

bind audio_tx_fifo atx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .link_en       (link_en),
   .dat_we        (dat_we),
   .pair_valid    (pair_valid),
   .pair_ready    (pair_ready),
   .fifo_level    (fifo_level),
   .st_empty      (st_empty),
   .st_half_empty (st_half_empty),
   .st_full       (st_full),
   .st_underrun   (st_underrun)
);

// File: tb/sim_audio_tx_fifo.sv
`timescale 1ns/1ps
module sim_audio_tx_fifo;
   localparam int DEPTH = 8;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link_en = 1'b1;
   logic        ctl_we = 1'b0, ctl_chan_en = 1'b0, ctl_compact = 1'b0;
   logic [1:0]  ctl_size = 2'd0, ctl_slot_en = 2'd0;
   logic        dat_we = 1'b0;
   logic [31:0] dat_word = '0;
   logic        clr_we = 1'b0, clr_underrun = 1'b0;
   logic        mask_we = 1'b0;
   logic [2:0]  mask_data = '0;
   logic        pair_valid, pair_ready = 1'b0;
   logic [19:0] pair_left, pair_right;
   logic [LVL_W-1:0] fifo_level;
   logic        st_empty, st_half_empty, st_full, st_underrun, irq;
   logic [2:0]  int_status;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   audio_tx_fifo #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .link_en(link_en),
      .ctl_we(ctl_we), .ctl_chan_en(ctl_chan_en), .ctl_size(ctl_size),
      .ctl_compact(ctl_compact), .ctl_slot_en(ctl_slot_en),
      .dat_we(dat_we), .dat_word(dat_word),
      .clr_we(clr_we), .clr_underrun(clr_underrun),
      .mask_we(mask_we), .mask_data(mask_data),
      .pair_valid(pair_valid), .pair_ready(pair_ready),
      .pair_left(pair_left), .pair_right(pair_right),
      .fifo_level(fifo_level), .st_empty(st_empty), .st_half_empty(st_half_empty),
      .st_full(st_full), .st_underrun(st_underrun),
      .int_status(int_status), .irq(irq)
   );

   // {size[75:74], compact[73], word[72:41], first[40:21], second[20:1], one_entry[0]}
   localparam logic [75:0] VEC [8] = '{
      {2'd0, 1'b0, 32'h0001_2345, 20'h23450, 20'h23450, 1'b1},
      {2'd1, 1'b0, 32'h0003_ABCD, 20'hEAF34, 20'hEAF34, 1'b1},
      {2'd2, 1'b0, 32'hFFF8_7654, 20'h87654, 20'h87654, 1'b1},
      {2'd3, 1'b0, 32'h0000_0ABC, 20'hABC00, 20'hABC00, 1'b1},
      {2'd0, 1'b1, 32'h1234_5678, 20'h56780, 20'h12340, 1'b0},
      {2'd3, 1'b1, 32'h0ABC_F123, 20'h12300, 20'hABC00, 1'b0},
      {2'd1, 1'b1, 32'h0001_1111, 20'h44444, 20'h44444, 1'b1},
      {2'd2, 1'b1, 32'h1234_5678, 20'h45678, 20'h45678, 1'b1}
   };

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic set_ctl(input logic en, input logic [1:0] sz, input logic cmp, input logic [1:0] slots);
      ctl_we = 1'b1; ctl_chan_en = en; ctl_size = sz; ctl_compact = cmp; ctl_slot_en = slots;
      @(negedge clk); ctl_we = 1'b0; #1;
   endtask

   task automatic wr(input logic [31:0] w);
      dat_we = 1'b1; dat_word = w;
      @(negedge clk); dat_we = 1'b0; #1;
   endtask

   task automatic set_mask(input logic [2:0] m);
      mask_we = 1'b1; mask_data = m;
      @(negedge clk); mask_we = 1'b0; #1;
   endtask

   task automatic flush_link();
      link_en = 1'b0;
      @(negedge clk); link_en = 1'b1; #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; #1;
      // reset state
      chk("R9", "reset level", 32'(fifo_level), 0);
      chk("R9", "reset flags e/h/f/u", {28'd0, st_empty, st_half_empty, st_full, st_underrun}, 32'hC);
      chk("R7", "reset int_status", 32'(int_status), 32'h6);
      chk("R7", "reset irq masked off", 32'(irq), 0);
      set_mask(3'b100);
      chk("R7", "complete int unmasked", 32'(irq), 1);

      // table walk: packing and normalization, pairs observed at the port
      for (int i = 0; i < 8; i++) begin
         pair_ready = 1'b0;
         flush_link();
         set_ctl(1'b1, VEC[i][75:74], VEC[i][73], 2'b01);
         repeat (VEC[i][0] ? 4 : 2) wr(VEC[i][72:41]);
         chk(VEC[i][73] && !VEC[i][75] ? "R2" : "R1", "vec level", 32'(fifo_level), 4);
         chk("R5", "vec valid", 32'(pair_valid), 1);
         chk(VEC[i][0] ? "R1" : "R2", "vec left", 32'(pair_left), 32'(VEC[i][40:21]));
         chk(VEC[i][0] ? "R1" : "R2", "vec right", 32'(pair_right), 32'(VEC[i][20:1]));
      end

      // fill to the top, overflow write, drain in order
      flush_link();
      set_ctl(1'b1, 2'd2, 1'b0, 2'b10);
      for (int k = 1; k <= 8; k++) wr(32'(k));
      chk("R4", "full level", 32'(fifo_level), 8);
      chk("R4", "full flags e/h/f", {29'd0, st_empty, st_half_empty, st_full}, 32'h1);
      wr(32'h99);
      chk("R3", "refused write level", 32'(fifo_level), 8);
      set_mask(3'b001);
      pair_ready = 1'b1;
      for (int p = 0; p < 4; p++) begin
         chk("R10", "drain valid", 32'(pair_valid), 1);
         chk("R5", "drain left", 32'(pair_left), 32'(2*p+1));
         chk("R5", "drain right", 32'(pair_right), 32'(2*p+2));
         @(negedge clk); #1;
         if (p == 0) chk("R6", "full cleared after pop", {30'd0, st_full, st_half_empty}, 0);
         if (p == 1) chk("R6", "half-empty at half", 32'(st_half_empty), 1);
      end
      pair_ready = 1'b0;
      chk("R6", "drained level", 32'(fifo_level), 0);
      chk("R6", "drained empty/underrun", {30'd0, st_empty, st_underrun}, 32'h3);
      chk("R7", "drained int_status", 32'(int_status), 32'h7);
      chk("R7", "underrun irq", 32'(irq), 1);
      clr_we = 1'b1; clr_underrun = 1'b1;
      @(negedge clk); clr_we = 1'b0; clr_underrun = 1'b0; #1;
      chk("R8", "underrun cleared", {30'd0, st_underrun, st_empty}, 32'h1);
      chk("R8", "irq after clear", 32'(irq), 0);

      // compact acceptance boundary
      flush_link();
      set_ctl(1'b1, 2'd0, 1'b1, 2'b01);
      wr(32'h0001_0002);
      chk("R4", "one compact word e/h", {30'd0, st_empty, st_half_empty}, 32'h1);
      wr(32'h0003_0004);
      chk("R4", "half-empty cleared at 4", 32'(st_half_empty), 0);
      wr(32'h0005_0006);
      chk("R3", "compact at 6", 32'(fifo_level), 6);
      wr(32'h0007_0008);
      chk("R3", "compact refused at 6", 32'(fifo_level), 6);
      set_ctl(1'b1, 2'd0, 1'b0, 2'b01);
      wr(32'h1); wr(32'h2);
      chk("R3", "non-compact fills to 8", {27'd0, st_full, fifo_level}, 32'h18);

      // release threshold and same-cycle push/pop
      flush_link();
      set_ctl(1'b1, 2'd2, 1'b0, 2'b01);
      pair_ready = 1'b1;
      wr(32'h1); wr(32'h2); wr(32'h3);
      chk("R5", "below half no valid", 32'(pair_valid), 0);
      wr(32'h4);
      chk("R5", "valid at half", 32'(pair_valid), 1);
      wr(32'h5);
      chk("R10", "push and pop net level", 32'(fifo_level), 3);
      chk("R10", "next pair left", 32'(pair_left), 3);
      @(negedge clk); #1;
      chk("R5", "single entry no valid", {27'd0, pair_valid, fifo_level}, 32'h01);
      pair_ready = 1'b0;

      // enable gating
      flush_link();
      set_ctl(1'b1, 2'd2, 1'b0, 2'b00);
      pair_ready = 1'b1;
      repeat (4) wr(32'hA);
      chk("R5", "no slot no valid", {27'd0, pair_valid, fifo_level}, 32'h04);
      set_ctl(1'b0, 2'd2, 1'b0, 2'b11);
      chk("R5", "channel off no valid", {27'd0, pair_valid, fifo_level}, 32'h04);
      set_ctl(1'b1, 2'd2, 1'b0, 2'b11);
      chk("R5", "enabled valid", 32'(pair_valid), 1);
      pair_ready = 1'b0;

      // burst ends when the codec stalls
      flush_link();
      set_ctl(1'b1, 2'd2, 1'b0, 2'b01);
      repeat (6) wr(32'hB);
      pair_ready = 1'b1;
      @(negedge clk); @(negedge clk); #1;
      chk("R5", "burst continues below half", {27'd0, pair_valid, fifo_level}, 32'h12);
      pair_ready = 1'b0;
      @(negedge clk); #1;
      chk("R5", "stall ends burst", {27'd0, pair_valid, fifo_level}, 32'h02);

      // clear against final pop
      flush_link();
      set_ctl(1'b1, 2'd2, 1'b0, 2'b01);
      repeat (4) wr(32'hC);
      pair_ready = 1'b1;
      @(negedge clk); #1;
      clr_we = 1'b1; clr_underrun = 1'b1;
      @(negedge clk); clr_we = 1'b0; clr_underrun = 1'b0; pair_ready = 1'b0; #1;
      chk("R8", "drain wins over clear", {30'd0, st_underrun, st_empty}, 32'h3);

      // flush during a write
      repeat (3) wr(32'hD);
      set_mask(3'b010);
      chk("R7", "half-empty irq", 32'(irq), 1);
      link_en = 1'b0; dat_we = 1'b1; dat_word = 32'hE;
      @(negedge clk); link_en = 1'b1; dat_we = 1'b0; #1;
      chk("R9", "flush level", 32'(fifo_level), 0);
      chk("R9", "flush flags e/h/f/u", {28'd0, st_empty, st_half_empty, st_full, st_underrun}, 32'hC);
      chk("R9", "mask cleared", 32'(irq), 0);
      repeat (4) wr(32'hF);
      chk("R9", "control cleared", {27'd0, pair_valid, fifo_level}, 32'h04);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule